// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked single-port word memory with byte lanes. A built-in two-bit counter produces the low address bits of a four-beat burst. A burst opens with either of two load strobes. Each later beat is stepped by an advance input, and a cycle without advance repeats the current word. The counter can walk the four beats in interleaved or linear order.

Reads can leave the block in two ways. In flow-through mode the array output goes straight to the data pins. In pipelined mode it passes through one output register. Deselecting the block takes effect with the same latency as read data, so the pins go quiet with the same delay. The output-enable and sleep inputs gate the pin drive without waiting for a clock. While asleep the block ignores every command and keeps its contents.

The data bus is split into `din_i`, `dout_o` and `doe_o`. A pad ring joins them into one tri-state bus, and `doe_o` low means high impedance.

Top module: `sburst_sram`

## Requirements
- R1: Every synchronous input is captured on the rising edge of `clk`. A load cycle happens when `ld_sec_n_i` is 0, or when `ld_pri_n_i` is 0 while `ce1_n_i` is 0. A primary strobe while `ce1_n_i` is 1 is treated as no strobe.
- R2: On a load cycle the block becomes selected only if `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0, and deselected otherwise. Chip-enable values on cycles that are not load cycles are ignored.
- R3: A load cycle takes the full address and clears the beat counter. While selected, a cycle with no load and `adv_n_i`=0 steps the counter by one, modulo 4. A cycle with no load and `adv_n_i`=1 accesses the same word again.
- R4: The accessed word is the loaded upper bits, joined with low bits equal to start XOR count when `linear_i`=0, or (start + count) mod 4 when `linear_i`=1.
- R5: With `pipe_i`=0, read data for a command captured at edge k is driven on `dout_o` between edge k and edge k+1.
- R6: With `pipe_i`=1, read data for a command captured at edge k is driven between edge k+1 and edge k+2.
- R7: After a load cycle that deselects, the pins stop driving with the read latency of the current mode. In pipelined mode they are never driven in the cycle after the second following edge.
- R8: A selected cycle with `gw_n_i`=0 or `bw_n_i`=0 is a write cycle. It updates the array at that edge, and its read slot leaves `doe_o` low.
- R9: With `gw_n_i`=0 all four bytes are written, regardless of the other write inputs. Otherwise, with `bw_n_i`=0, byte i (data bits 8i+7..8i) is written when `be_n_i[i]`=0.
- R10: A load through the primary strobe is always a read. Write inputs on that cycle leave the array unchanged.
- R11: `doe_o` is 0 during reset, and is 0 at once, with no clock, while `oe_n_i`=1.
- R12: While `sleep_i`=1, `doe_o` is 0 at once, every command is ignored, array contents are kept, and pending read slots are dropped. The first edge with `sleep_i`=0 accepts commands again.
- R13: A fresh address may be loaded on every cycle, giving one access per cycle with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, taken on load cycles |
| din_i | input | BYTES*BYTE_W | Write data |
| dout_o | output | BYTES*BYTE_W | Read data toward the pad |
| doe_o | output | 1 | Pad drive enable, 0 means high impedance |
| ce1_n_i | input | 1 | Chip enable one, active low; also gates the primary strobe |
| ce2_i | input | 1 | Chip enable two, active high |
| ce3_n_i | input | 1 | Chip enable three, active low |
| ld_pri_n_i | input | 1 | Primary load strobe, active low, always a read |
| ld_sec_n_i | input | 1 | Secondary load strobe, active low, read or write |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Write all bytes, active low |
| bw_n_i | input | 1 | Byte-write enable, active low |
| be_n_i | input | BYTES | Per-byte write select, active low |
| linear_i | input | 1 | 1 selects linear beat order, 0 interleaved |
| pipe_i | input | 1 | 1 selects registered reads, 0 flow-through |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |

## Verification
The array is first filled by back-to-back single-word writes. It is then read back the same way in each read mode, which sets the one-cycle latency gap between flow-through and pipelined output. Four-beat bursts from every start offset in both orders tell XOR sequencing from modular addition, and held advance cycles show that the counter waits. Short directed runs cover a primary strobe with chip enable one high, a primary-strobe load that carries write inputs, partial byte masks, deselect timing, and asynchronous drive gating through output enable and sleep. A long seeded random run then mixes all of these against a bench model of the array and both read slots.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    logic [1:0] r;
    if (linear) r = start + step;
    else        r = start ^ step;
    return r;
  endfunction

endpackage

// File: rtl/sburst_addr.sv
module sburst_addr
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              adv,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q, base_d;
  logic [1:0]      start_q, start_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            upd;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (load) begin
      base_d  = addr_i[ADDR_W-1:2];
      start_d = addr_i[1:0];
      cnt_d   = 2'd0;
    end else if (adv) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  assign upd        = en & (load | adv);
  assign acc_addr_o = {base_d, burst_lsb(start_d, cnt_d, linear_i)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
    end else if (upd) begin
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || (!load && !adv)) |=> $stable(cnt_q)); // R3
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (cnt_q == 2'd0)); // R3

endmodule

// File: rtl/sburst_mem.sv
module sburst_mem #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        wr_be_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);

  localparam int WORDS = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_q [WORDS];

    always_ff @(posedge clk) begin
      if (wr_be_i[b]) begin
        lane_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = lane_q[raddr_i];
  end

endmodule

// File: rtl/sburst_rdpath.sv
module sburst_rdpath #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rd_cmd_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              pipe_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              doe_o
);

  logic              st1_q, st1_d;
  logic              st2_q, st2_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              drive;

  always_comb begin
    st1_d = en & rd_cmd_i;
    st2_d = en & st1_q;
    ra_d  = (en & rd_cmd_i) ? acc_addr_i : ra_q;
    dq_d  = (en & st1_q) ? mem_rdata_i : dq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
      ra_q  <= '0;
      dq_q  <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
      ra_q  <= ra_d;
      dq_q  <= dq_d;
    end
  end

  assign raddr_o = ra_q;
  assign drive   = pipe_i ? st2_q : st1_q;
  assign dout_o  = pipe_i ? dq_q : mem_rdata_i;
  assign doe_o   = drive & ~oe_n_i & ~sleep_i;

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !doe_o); // R12

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] din_i,
  output logic [BYTES*BYTE_W-1:0] dout_o,
  output logic                    doe_o,
  input  logic                    ce1_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    ld_pri_n_i,
  input  logic                    ld_sec_n_i,
  input  logic                    adv_n_i,
  input  logic                    gw_n_i,
  input  logic                    bw_n_i,
  input  logic [BYTES-1:0]        be_n_i,
  input  logic                    linear_i,
  input  logic                    pipe_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i
);

  localparam int DATA_W = BYTES * BYTE_W;

  logic              en, ld_pri, load, sel_now, wr_req, adv;
  logic              act_q, act_d;
  op_e               op;
  logic [BYTES-1:0]  wr_be;
  logic [ADDR_W-1:0] acc_addr, raddr;
  logic [DATA_W-1:0] rdata;

  // command decode
  always_comb begin
    en      = ~sleep_i;
    ld_pri  = ~ld_pri_n_i & ~ce1_n_i;
    load    = en & (ld_pri | ~ld_sec_n_i);
    sel_now = ~ce1_n_i & ce2_i & ~ce3_n_i;
    wr_req  = ~gw_n_i | ~bw_n_i;
    adv     = en & ~load & act_q & ~adv_n_i;
    act_d   = load ? sel_now : act_q;
  end

  always_comb begin
    op = OP_IDLE;
    if (en) begin
      if (load) begin
        if (sel_now) op = (ld_pri | ~wr_req) ? OP_READ : OP_WRITE;
      end else if (act_q) begin
        op = wr_req ? OP_WRITE : OP_READ;
      end
    end
  end

  always_comb begin
    wr_be = '0;
    if (op == OP_WRITE) begin
      if (!gw_n_i)      wr_be = '1;
      else if (!bw_n_i) wr_be = ~be_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  sburst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .load       (load),
    .adv        (adv),
    .linear_i   (linear_i),
    .addr_i     (addr_i),
    .acc_addr_o (acc_addr)
  );

  sburst_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk     (clk),
    .wr_be_i (wr_be),
    .waddr_i (acc_addr),
    .wdata_i (din_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  sburst_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .rd_cmd_i    (op == OP_READ),
    .acc_addr_i  (acc_addr),
    .pipe_i      (pipe_i),
    .oe_n_i      (oe_n_i),
    .sleep_i     (sleep_i),
    .mem_rdata_i (rdata),
    .raddr_o     (raddr),
    .dout_o      (dout_o),
    .doe_o       (doe_o)
  );

  AST_PRI_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !ld_pri_n_i && !ce1_n_i) |-> (wr_be == '0)); // R10
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && !pipe_i) |=> (pipe_i || !doe_o)); // R8
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_now && pipe_i) |=> ##1 (!pipe_i || !doe_o)); // R7

endmodule

// File: tb/sim_sburst_sram.sv
module sim_sburst_sram;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          doe;
  logic          ce1_n, ce2, ce3_n, lpri_n, lsec_n, adv_n, gw_n, bw_n;
  logic [NB-1:0] be_n;
  logic          lin, pipe, oe_n, sleep;

  int nchk = 0;
  int nbad = 0;

  // bench model
  logic [DW-1:0] m_mem [64];
  bit            m_act;
  logic [3:0]    m_base;
  logic [1:0]    m_start, m_cnt;
  bit            fl_v, pp_v;
  logic [DW-1:0] fl_d, pp_d;

  always #4 clk = ~clk;

  sburst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din), .dout_o(dout),
    .doe_o(doe), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .ld_pri_n_i(lpri_n), .ld_sec_n_i(lsec_n), .adv_n_i(adv_n),
    .gw_n_i(gw_n), .bw_n_i(bw_n), .be_n_i(be_n), .linear_i(lin),
    .pipe_i(pipe), .oe_n_i(oe_n), .sleep_i(sleep)
  );

  function automatic logic [1:0] beat(input logic [1:0] s, input logic [1:0] c,
                                      input bit l);
    logic [1:0] r;
    r = l ? 2'(s + c) : (s ^ c);
    return r;
  endfunction

  task automatic model_edge();
    bit pri, ld, sel, wr;
    int op;
    logic [AW-1:0] a;
    if (sleep) begin
      fl_v = 0;
      pp_v = 0;
      return;
    end
    pri = !lpri_n && !ce1_n;
    ld  = pri || !lsec_n;
    sel = !ce1_n && ce2 && !ce3_n;
    wr  = !gw_n || !bw_n;
    op  = 0;
    if (ld) begin
      m_act = sel; m_base = addr[5:2]; m_start = addr[1:0]; m_cnt = 2'd0;
      if (sel) op = (pri || !wr) ? 1 : 2;
    end else if (m_act) begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      op = wr ? 2 : 1;
    end
    a = {m_base, beat(m_start, m_cnt, lin)};
    pp_v = fl_v;
    pp_d = fl_d;
    if (op == 2) begin
      for (int b = 0; b < NB; b++)
        if (!gw_n || !be_n[b]) m_mem[a][b*8 +: 8] = din[b*8 +: 8];
    end
    fl_v = (op == 1);
    if (fl_v) fl_d = m_mem[a];
  endtask

  task automatic check(input string tag);
    bit            e_oe;
    logic [DW-1:0] e_d;
    e_oe = (pipe ? pp_v : fl_v) && !oe_n && !sleep;
    e_d  = pipe ? pp_d : fl_d;
    nchk++;
    if (doe !== e_oe) begin
      nbad++;
      $display("FAIL %s doe_o actual %0b expected %0b at %0t", tag, doe, e_oe, $time);
    end else if (e_oe) begin
      nchk++;
      if (dout !== e_d) begin
        nbad++;
        $display("FAIL %s dout_o actual %h expected %h at %0t", tag, dout, e_d, $time);
      end
    end
  endtask

  task automatic quiet();
    lpri_n = 1; lsec_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; be_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; din = '0;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
    quiet();
  endtask

  task automatic load_sec(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                          input string tag);
    addr = a; lsec_n = 0; gw_n = !w; din = d;
    cyc(tag);
  endtask

  task automatic step(input string tag);
    adv_n = 0;
    cyc(tag);
  endtask

  task automatic desel(input string tag);
    lsec_n = 0; ce2 = 0;
    cyc(tag);
  endtask

  initial begin
    #1200000;
    nbad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7031));
    rst_n = 0; addr = '0; lin = 0; pipe = 0; oe_n = 0; sleep = 0;
    quiet();
    m_act = 0; m_base = '0; m_start = '0; m_cnt = '0;
    fl_v = 0; pp_v = 0; fl_d = '0; pp_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11");
    rst_n = 1;
    @(negedge clk);
    check("R11");

    // back-to-back fill, then back-to-back readback in both modes
    for (int i = 0; i < 64; i++) load_sec(AW'(i), 1, $urandom, "R13");
    for (int i = 0; i < 64; i++) load_sec(AW'(i), 0, '0, "R5");
    desel("R5");
    pipe = 1;
    for (int i = 0; i < 64; i++) load_sec(AW'(63 - i), 0, '0, "R6");
    desel("R6"); desel("R6");

    // bursts from every offset, both orders, both modes
    for (int m = 0; m < 4; m++) begin
      pipe = m[0]; lin = m[1];
      for (int s = 0; s < 4; s++) begin
        load_sec({4'(9 + m), 2'(s)}, 0, '0, "R4");
        step("R4"); step("R4"); step("R4"); step("R4");
      end
      desel("R4"); desel("R4");
    end

    // advance held high repeats the word
    pipe = 0; lin = 0;
    load_sec(6'd22, 0, '0, "R3");
    step("R3"); cyc("R3"); cyc("R3"); step("R3");
    desel("R3");

    // write slot gives no drive
    for (int m = 0; m < 2; m++) begin
      pipe = m[0];
      load_sec(6'd3, 0, '0, "R8");
      load_sec(6'd3, 1, 32'hC0DE_0000 + 32'(m), "R8");
      load_sec(6'd3, 0, '0, "R8");
      desel("R8"); desel("R8");
    end

    // byte masks
    pipe = 0;
    addr = 6'd10; lsec_n = 0; bw_n = 0; be_n = 4'b1010; din = 32'h1122_3344; cyc("R9");
    addr = 6'd11; lsec_n = 0; gw_n = 0; bw_n = 1; be_n = 4'b1111; din = 32'h5566_7788; cyc("R9");
    addr = 6'd12; lsec_n = 0; gw_n = 0; bw_n = 0; be_n = 4'b0111; din = 32'h99AA_BBCC; cyc("R9");
    load_sec(6'd10, 0, '0, "R9");
    load_sec(6'd11, 0, '0, "R9");
    load_sec(6'd12, 0, '0, "R9");
    desel("R9");

    // primary strobe always reads
    addr = 6'd12; lpri_n = 0; gw_n = 0; din = 32'hFFFF_FFFF; cyc("R10");
    load_sec(6'd12, 0, '0, "R10");
    desel("R10");

    // primary strobe with ce1_n high is no strobe
    load_sec(6'd20, 0, '0, "R1");
    addr = 6'd40; lpri_n = 0; ce1_n = 1; cyc("R1");
    cyc("R1");
    desel("R1");

    // chip enables only matter on loads
    addr = 6'd5; lsec_n = 0; ce2 = 0; cyc("R2");
    cyc("R2");
    addr = 6'd5; lsec_n = 0; ce3_n = 1; cyc("R2");
    load_sec(6'd5, 0, '0, "R2");
    ce1_n = 1; ce3_n = 1; step("R2");
    desel("R2");

    // deselect latency in pipelined mode
    pipe = 1;
    load_sec(6'd30, 0, '0, "R7");
    load_sec(6'd31, 0, '0, "R7");
    desel("R7"); cyc("R7"); cyc("R7");

    // asynchronous output enable
    pipe = 0;
    load_sec(6'd33, 0, '0, "R11");
    oe_n = 1; #1 check("R11");
    oe_n = 0; #1 check("R11");
    desel("R11");

    // sleep
    load_sec(6'd34, 0, '0, "R12");
    sleep = 1; #1 check("R12");
    sleep = 1; addr = 6'd34; lsec_n = 0; gw_n = 0; din = 32'hDEAD_BEEF; cyc("R12");
    sleep = 1; cyc("R12");
    sleep = 0; #1 check("R12");
    cyc("R12");
    load_sec(6'd34, 0, '0, "R12");
    desel("R12");

    // seeded random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      addr   = AW'($urandom);
      din    = $urandom;
      lsec_n = ($urandom % 4) != 0;
      lpri_n = ($urandom % 6) != 0;
      adv_n  = ($urandom % 2) != 0;
      ce1_n  = ($urandom % 10) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 10) == 0;
      gw_n   = ($urandom % 5) != 0;
      bw_n   = ($urandom % 4) != 0;
      be_n   = NB'($urandom);
      sleep  = (r < 5);
      oe_n   = (r >= 5 && r < 10);
      if (r == 50) pipe = ~pipe;
      if (r == 51) lin  = ~lin;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(pipe ? "R6" : "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

endmodule